// File: doc/BRIEF.md
# Power-Management Register Target on I2C

This block is an I2C target that presents a byte-wide configuration space of 186 locations, indexed 0x00 to 0xB9, as seen by a host talking to a power-management controller. It contains the complete bit-level target: it samples SCL and SDA into the system clock domain, recognises START and STOP conditions, matches a 7-bit target address, acknowledges, shifts bytes in and out, and drives SDA through an open-drain enable when it returns data.

A host sets the location it wants to access by writing one byte after the address, which goes into an internal 8-bit pointer. Reads stream out from the pointer and advance it. A single location, 0x23, accepts data from the bus. Every other location holds a constant value that comes from reset. Writes aimed at a constant location are discarded and leave the pointer where it was. Reads past the top of the space return 0xFF and do not move the pointer. The pointer survives START, repeated START and STOP, so a write that sets the pointer, followed by a repeated START and a read, returns data from the chosen location.

Top module: `pmu_i2c_target`

## Requirements
- R1: After reset, location 0x03 reads 0x01, location 0x23 reads 0x16, location 0x40 reads 0xD8, and every other location from 0x00 to 0xB9 reads 0x00.
- R2: The target acknowledges (pulls SDA low in the ninth clock) a header whose upper seven bits equal the parameter TGT_ADDR (default 0x34). For any other header it never pulls SDA low until the next START.
- R3: In a write, the first data byte after the header is acknowledged and loaded into the pointer, and is not stored in any location.
- R4: A later data byte in the same write, while the pointer equals 0x23, is acknowledged, stored in location 0x23, and the pointer advances by one.
- R5: A later data byte while the pointer is any value other than 0x23 is acknowledged but discarded, and the pointer does not move.
- R6: In a read (header bit 0 = 1), each byte is sent most significant bit first. It is the location at the pointer, and the pointer then advances by one.
- R7: A read with the pointer at 0xBA or above returns 0xFF and leaves the pointer unchanged.
- R8: Every START, repeated START or STOP makes the next write again treat its first data byte as the pointer.
- R9: The pointer keeps its value across START, repeated START and STOP, so a read continues from the last pointer value.
- R10: During a read the target releases SDA in the ninth clock of each byte. If the host answers NACK (SDA high), the target stops driving until the next START.
- R11: While rst_ni is low at a clock edge, the pointer returns to 0x00, location 0x23 returns to 0x16, and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; SCL and SDA are oversampled on it |
| rst_ni | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe_o | output | 1 | Open-drain enable; 1 pulls SDA low |

## Verification
The bench goes after pointer bookkeeping. A design that wrote every location, or advanced the pointer on a dropped write, would return the wrong location on the following read. A design that forgot to clear its first-byte flag on a bus event would read the next pointer byte as data, and location 0x23 would keep its old value. Reads across the top of the map catch a pointer that wraps or keeps counting. A NACK followed by extra clock pulses shows whether a target keeps driving data after the host has given up. A foreign header shows whether a target acknowledges traffic meant for another device.

// File: rtl/pmu_i2c_pkg.sv
package pmu_i2c_pkg;

  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_RX,
    ST_DACK,
    ST_TX,
    ST_MACK
  } link_st_e;

  // constant contents of the configuration space after reset
  localparam logic [BYTE_W-1:0] VER_LOC  = 8'h03;
  localparam logic [BYTE_W-1:0] VER_VAL  = 8'h01;
  localparam logic [BYTE_W-1:0] VOUT_LOC = 8'h23;
  localparam logic [BYTE_W-1:0] VOUT_VAL = 8'h16;
  localparam logic [BYTE_W-1:0] IRQE_LOC = 8'h40;
  localparam logic [BYTE_W-1:0] IRQE_VAL = 8'hD8;

  function automatic logic [BYTE_W-1:0] reset_byte(input logic [BYTE_W-1:0] loc);
    logic [BYTE_W-1:0] v;
    v = '0;
    if (loc == VER_LOC)  v = VER_VAL;
    if (loc == VOUT_LOC) v = VOUT_VAL;
    if (loc == IRQE_LOC) v = IRQE_VAL;
    return v;
  endfunction

  function automatic logic [BYTE_W-1:0] shift_in(input logic [BYTE_W-1:0] cur, input logic bit_i);
    return {cur[BYTE_W-2:0], bit_i};
  endfunction

endpackage

// File: rtl/pmu_i2c_busmon.sv
module pmu_i2c_busmon #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);

  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_d, sda_d, scl_s;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_d  <= scl_ff[STAGES-1];
      sda_d  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s      = scl_ff[STAGES-1];
  assign sda_o      = sda_ff[STAGES-1];
  assign scl_rise_o = scl_s & ~scl_d;
  assign scl_fall_o = ~scl_s & scl_d;
  // conditions only count while SCL has been high on both samples
  assign start_o    = scl_s & scl_d & sda_d & ~sda_o;
  assign stop_o     = scl_s & scl_d & ~sda_d & sda_o;

endmodule

// File: rtl/pmu_i2c_link.sv
module pmu_i2c_link
  import pmu_i2c_pkg::*;
#(
  parameter logic [6:0] TGT_ADDR = 7'h34
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              sda_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              sda_oe_o,
  output logic              wr_stb_o,
  output logic [BYTE_W-1:0] wr_byte_o,
  output logic              rd_stb_o
);

  localparam logic [3:0] BITS_DONE = 4'(BYTE_W);

  link_st_e          st_q;
  logic [3:0]        bitcnt_q;
  logic [BYTE_W-1:0] sh_q;
  logic              rw_q, oe_q, mack_q;
  logic              quiet, byte_end;

  assign quiet    = ~start_i & ~stop_i;
  assign byte_end = scl_fall_i & (bitcnt_q == BITS_DONE);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      bitcnt_q <= '0;
      sh_q     <= '0;
      rw_q     <= 1'b0;
      oe_q     <= 1'b0;
      mack_q   <= 1'b0;
    end else if (start_i) begin
      st_q     <= ST_ADDR;
      bitcnt_q <= '0;
      oe_q     <= 1'b0;
    end else if (stop_i) begin
      st_q <= ST_IDLE;
      oe_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_ADDR: begin
          if (scl_rise_i) begin
            sh_q     <= shift_in(sh_q, sda_i);
            bitcnt_q <= bitcnt_q + 4'd1;
          end else if (byte_end) begin
            if (sh_q[BYTE_W-1:1] == TGT_ADDR) begin
              rw_q <= sh_q[0];
              oe_q <= 1'b1;
              st_q <= ST_AACK;
            end else begin
              st_q <= ST_IDLE;
            end
          end
        end
        ST_AACK: begin
          if (scl_fall_i) begin
            bitcnt_q <= '0;
            if (rw_q) begin
              sh_q <= rd_data_i;
              oe_q <= ~rd_data_i[BYTE_W-1];
              st_q <= ST_TX;
            end else begin
              oe_q <= 1'b0;
              st_q <= ST_RX;
            end
          end
        end
        ST_RX: begin
          if (scl_rise_i) begin
            sh_q     <= shift_in(sh_q, sda_i);
            bitcnt_q <= bitcnt_q + 4'd1;
          end else if (byte_end) begin
            oe_q <= 1'b1;
            st_q <= ST_DACK;
          end
        end
        ST_DACK: begin
          if (scl_fall_i) begin
            oe_q     <= 1'b0;
            bitcnt_q <= '0;
            st_q     <= ST_RX;
          end
        end
        ST_TX: begin
          if (scl_rise_i) begin
            bitcnt_q <= bitcnt_q + 4'd1;
          end else if (byte_end) begin
            oe_q <= 1'b0;
            st_q <= ST_MACK;
          end else if (scl_fall_i) begin
            sh_q <= {sh_q[BYTE_W-2:0], 1'b0};
            oe_q <= ~sh_q[BYTE_W-2];
          end
        end
        ST_MACK: begin
          if (scl_rise_i) begin
            mack_q <= ~sda_i;
          end else if (scl_fall_i) begin
            if (mack_q) begin
              sh_q     <= rd_data_i;
              oe_q     <= ~rd_data_i[BYTE_W-1];
              bitcnt_q <= '0;
              st_q     <= ST_TX;
            end else begin
              st_q <= ST_IDLE;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign sda_oe_o  = oe_q;
  assign wr_byte_o = sh_q;
  assign wr_stb_o  = quiet & (st_q == ST_RX) & byte_end;
  assign rd_stb_o  = quiet & scl_fall_i &
                     (((st_q == ST_AACK) & rw_q) | ((st_q == ST_MACK) & mack_q));

endmodule

// File: rtl/pmu_i2c_regs.sv
module pmu_i2c_regs
  import pmu_i2c_pkg::*;
#(
  parameter int                NUM_REGS = 186,
  parameter logic [BYTE_W-1:0] WR_ADDR  = 8'h23
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_evt_i,
  input  logic              wr_stb_i,
  input  logic [BYTE_W-1:0] wr_byte_i,
  input  logic              rd_stb_i,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic [BYTE_W-1:0] ptr_o,
  output logic              ptr_loaded_o
);

  localparam logic [BYTE_W-1:0] LAST_PLUS1 = BYTE_W'(NUM_REGS);

  logic [BYTE_W-1:0] ptr_q, wreg_q;
  logic              loaded_q, in_map;

  assign in_map = ptr_q < LAST_PLUS1;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      ptr_q    <= '0;
      wreg_q   <= reset_byte(WR_ADDR);
      loaded_q <= 1'b0;
    end else begin
      if (bus_evt_i) loaded_q <= 1'b0;
      if (wr_stb_i) begin
        if (!loaded_q) begin
          ptr_q    <= wr_byte_i;
          loaded_q <= 1'b1;
        end else if (ptr_q == WR_ADDR) begin
          wreg_q <= wr_byte_i;
          ptr_q  <= ptr_q + 1'b1;
        end
      end else if (rd_stb_i && in_map) begin
        ptr_q <= ptr_q + 1'b1;
      end
    end
  end

  assign rd_data_o    = !in_map ? '1 : (ptr_q == WR_ADDR) ? wreg_q : reset_byte(ptr_q);
  assign ptr_o        = ptr_q;
  assign ptr_loaded_o = loaded_q;

endmodule

// File: rtl/pmu_i2c_target.sv
module pmu_i2c_target
  import pmu_i2c_pkg::*;
#(
  parameter logic [6:0]        TGT_ADDR    = 7'h34,
  parameter int                NUM_REGS    = 186,
  parameter logic [BYTE_W-1:0] WR_ADDR     = 8'h23,
  parameter int                SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o
);

  logic              sda_s, scl_rise, scl_fall, start_evt, stop_evt, bus_evt;
  logic              wr_stb, rd_stb, ptr_loaded;
  logic [BYTE_W-1:0] wr_byte, rd_data, ptr;

  pmu_i2c_busmon #(.STAGES(SYNC_STAGES)) busmon_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_evt),
    .stop_o     (stop_evt)
  );

  assign bus_evt = start_evt | stop_evt;

  pmu_i2c_link #(.TGT_ADDR(TGT_ADDR)) link_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .sda_i      (sda_s),
    .start_i    (start_evt),
    .stop_i     (stop_evt),
    .rd_data_i  (rd_data),
    .sda_oe_o   (sda_oe_o),
    .wr_stb_o   (wr_stb),
    .wr_byte_o  (wr_byte),
    .rd_stb_o   (rd_stb)
  );

  pmu_i2c_regs #(.NUM_REGS(NUM_REGS), .WR_ADDR(WR_ADDR)) regs_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .bus_evt_i    (bus_evt),
    .wr_stb_i     (wr_stb),
    .wr_byte_i    (wr_byte),
    .rd_stb_i     (rd_stb),
    .rd_data_o    (rd_data),
    .ptr_o        (ptr),
    .ptr_loaded_o (ptr_loaded)
  );

endmodule

// File: rtl/pmu_i2c_target_chk.sv
module pmu_i2c_target_chk #(
  parameter int         NUM_REGS = 186,
  parameter logic [7:0] WR_ADDR  = 8'h23
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sda_oe_o,
  input logic       stop_evt,
  input logic       bus_evt,
  input logic       wr_stb,
  input logic [7:0] wr_byte,
  input logic       rd_stb,
  input logic [7:0] ptr,
  input logic       ptr_loaded
);

  localparam logic [7:0] END_L = 8'(NUM_REGS);

  AST_PTR_FROM_FIRST_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb && !ptr_loaded |=> ptr == $past(wr_byte)); // R3
  AST_WR_LOC_ADVANCES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb && ptr_loaded && ptr == WR_ADDR |=> ptr == $past(ptr) + 8'd1); // R4
  AST_DROPPED_WR_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb && ptr_loaded && ptr != WR_ADDR |=> $stable(ptr)); // R5
  AST_RD_ADVANCES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_stb && ptr < END_L |=> ptr == $past(ptr) + 8'd1); // R6
  AST_RD_PAST_END_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_stb && ptr >= END_L |=> $stable(ptr)); // R7
  AST_EVT_REARMS_PTR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_evt |=> !ptr_loaded); // R8
  AST_EVT_KEEPS_PTR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_evt |=> $stable(ptr)); // R9
  AST_STOP_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_evt |=> !sda_oe_o); // R10

endmodule

bind pmu_i2c_target pmu_i2c_target_chk #(.NUM_REGS(NUM_REGS), .WR_ADDR(WR_ADDR)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sda_oe_o   (sda_oe_o),
  .stop_evt   (stop_evt),
  .bus_evt    (bus_evt),
  .wr_stb     (wr_stb),
  .wr_byte    (wr_byte),
  .rd_stb     (rd_stb),
  .ptr        (ptr),
  .ptr_loaded (ptr_loaded)
);

// File: tb/pmu_i2c_target_tb_top.sv
module pmu_i2c_target_tb_top;

  localparam int         HP  = 12;
  localparam logic [6:0] ME  = 7'h34;
  localparam int         MAP = 186;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_oe;
  logic sda_line;
  assign sda_line = m_sda & ~sda_oe;

  pmu_i2c_target dut_i (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .scl_i    (m_scl),
    .sda_i    (sda_line),
    .sda_oe_o (sda_oe)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit may_drive = 1'b0;

  // behavioural reference: storage, pointer, first-byte flag
  int mreg [MAP];
  int mptr;
  bit mfirst;

  task automatic model_reset();
    for (int i = 0; i < MAP; i++) mreg[i] = 0;
    mreg[8'h03] = 8'h01;
    mreg[8'h23] = 8'h16;
    mreg[8'h40] = 8'hD8;
    mptr = 0;
    mfirst = 1'b1;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // every clock: the target must not pull SDA outside the windows the bench allows
  always @(negedge clk) begin
    cyc++;
    if (rst_n && !may_drive) check(!sda_oe, "R2/R10 unexpected drive", sda_oe, 0);
    if (cyc > 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic bus_start();
    tick(2); m_sda = 1'b1; tick(HP);
    m_scl = 1'b1; tick(HP);
    m_sda = 1'b0; tick(HP);
    m_scl = 1'b0; tick(2);
    mfirst = 1'b1;
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(HP);
    m_scl = 1'b1; tick(HP);
    m_sda = 1'b1; tick(HP);
    mfirst = 1'b1;
  endtask

  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input bit keep, input string req);
    bit ack;
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; tick(HP);
      m_scl = 1'b1; tick(HP);
      m_scl = 1'b0; tick(2);
    end
    m_sda = 1'b1;
    may_drive = exp_ack;
    tick(HP);
    m_scl = 1'b1; tick(HP/2);
    ack = !sda_line;
    check(ack == exp_ack, req, ack, exp_ack);
    tick(HP/2);
    m_scl = 1'b0;
    if (!keep) begin
      tick(8);
      may_drive = 1'b0;
    end
  endtask

  task automatic recv_byte(input bit last, output logic [7:0] b);
    may_drive = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(HP);
      m_scl = 1'b1; tick(HP/2);
      b[i] = sda_line;
      tick(HP/2);
      m_scl = 1'b0; tick(2);
    end
    m_sda = last ? 1'b1 : 1'b0;
    tick(HP);
    m_scl = 1'b1; tick(HP);
    m_scl = 1'b0; tick(2);
    m_sda = 1'b1;
    if (last) begin
      tick(6);
      may_drive = 1'b0;
    end
  endtask

  task automatic do_write(input logic [6:0] a, input int n, input logic [7:0] b0,
                          input logic [7:0] b1, input logic [7:0] b2);
    logic [7:0] b;
    bit hit;
    hit = (a == ME);
    bus_start();
    send_byte({a, 1'b0}, hit, 1'b0, "R2 header ack");
    for (int k = 0; k < n; k++) begin
      b = (k == 0) ? b0 : (k == 1) ? b1 : b2;
      send_byte(b, hit, 1'b0, "R3 data ack");
      if (hit) begin
        if (mfirst) begin
          mptr = int'(b);
          mfirst = 1'b0;
        end else if (mptr == 8'h23) begin
          mreg[8'h23] = int'(b);
          mptr++;
        end
      end
    end
  endtask

  task automatic do_read(input int n, input string req);
    logic [7:0] got;
    int exp;
    bus_start();
    send_byte({ME, 1'b1}, 1'b1, 1'b1, "R2 read header ack");
    for (int i = 0; i < n; i++) begin
      recv_byte(i == n - 1, got);
      if (mptr < MAP) begin
        exp = mreg[mptr];
        mptr++;
      end else begin
        exp = 8'hFF;
      end
      check(int'(got) == exp, req, got, exp);
    end
  endtask

  initial begin
    logic [7:0] dummy;
    model_reset();
    tick(5);
    rst_n = 1'b1;
    tick(5);
    check(sda_oe == 1'b0, "R11 released after reset", sda_oe, 0);

    // R11 pointer from reset is 0: stream 0x00..0x03
    do_read(4, "R11 R1 R6 read from reset pointer");
    bus_stop();

    // R1 R6 R9: pointer write, repeated START, streaming read
    do_write(ME, 1, 8'h00, 8'h00, 8'h00);
    do_read(8, "R1 R6 R9 low locations");
    bus_stop();
    do_write(ME, 1, 8'h21, 8'h00, 8'h00);
    do_read(4, "R1 R6 around 0x23");
    bus_stop();
    do_write(ME, 1, 8'h3E, 8'h00, 8'h00);
    do_read(4, "R1 R6 around 0x40");
    bus_stop();

    // R2: foreign header is ignored; location 0x23 untouched
    do_write(7'h35, 2, 8'h23, 8'h99, 8'h00);
    bus_stop();
    do_write(ME, 1, 8'h23, 8'h00, 8'h00);
    do_read(1, "R2 foreign write had no effect");
    bus_stop();

    // R4 R5: store into 0x23, next byte dropped at 0x24, pointer held at 0x24
    do_write(ME, 3, 8'h23, 8'h5A, 8'h77);
    bus_stop();
    do_read(2, "R4 R5 R9 pointer after stored byte");
    bus_stop();
    do_write(ME, 1, 8'h23, 8'h00, 8'h00);
    do_read(1, "R4 stored value");
    bus_stop();

    // R5: write to a constant location is dropped and the pointer stays
    do_write(ME, 3, 8'h10, 8'h99, 8'h55);
    do_read(2, "R5 dropped write");
    bus_stop();

    // R8: byte counter re-armed by STOP and by repeated START
    do_write(ME, 1, 8'h05, 8'h00, 8'h00);
    bus_stop();
    do_write(ME, 2, 8'h23, 8'h42, 8'h00);
    bus_stop();
    do_write(ME, 1, 8'h23, 8'h00, 8'h00);
    do_read(1, "R8 after STOP");
    bus_stop();
    do_write(ME, 1, 8'h06, 8'h00, 8'h00);
    do_write(ME, 2, 8'h23, 8'h43, 8'h00);
    do_write(ME, 1, 8'h23, 8'h00, 8'h00);
    do_read(1, "R8 after repeated START");
    bus_stop();

    // R7: across the top of the map
    do_write(ME, 1, 8'hB8, 8'h00, 8'h00);
    do_read(4, "R7 crossing end of map");
    bus_stop();
    do_read(2, "R7 pointer held past end");
    bus_stop();

    // R10: after NACK the target stays off the bus while SCL keeps toggling
    do_write(ME, 1, 8'h03, 8'h00, 8'h00);
    do_read(1, "R10 byte before NACK");
    for (int i = 0; i < 9; i++) begin
      tick(HP);
      m_scl = 1'b1; tick(HP/2);
      check(sda_line == 1'b1, "R10 SDA released after NACK", sda_line, 1);
      tick(HP/2);
      m_scl = 1'b0; tick(2);
    end
    bus_stop();

    // R11: reset restores location 0x23 and the pointer
    do_write(ME, 2, 8'h23, 8'h3C, 8'h00);
    bus_stop();
    rst_n = 1'b0;
    tick(3);
    check(sda_oe == 1'b0, "R11 SDA released in reset", sda_oe, 0);
    rst_n = 1'b1;
    model_reset();
    tick(5);
    do_read(4, "R11 pointer back to zero");
    bus_stop();
    do_write(ME, 1, 8'h23, 8'h00, 8'h00);
    do_read(1, "R11 location 0x23 restored");
    bus_stop();

    dummy = 8'h00;
    tick(20 + int'(dummy));
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule